// File: doc/BRIEF.md
# Card Bus Clock Gating Controller

This block produces the serial clock for a memory card host interface from a faster base clock. It has two outputs: a one-cycle enable strobe, `tick_o`, that marks each card clock event, and a square-ish card clock, `card_clk_o`, that toggles on every strobe. The controller stays silent after reset and starts only when the interface enable input is high. When the bus is busy, or when power saving is off, it strobes on every base clock cycle.

When power saving is on and the bus is idle, strobes are spaced by `2^N + 1` base cycles, where `N` is the 3-bit idle divider field. The controller can also halt strobes during a transfer when the FIFO cannot keep up. During a read it halts while the receive FIFO is full. During a write it halts while the transmit FIFO is empty. Each direction has its own proof enable, so the hold can be turned on for reads, for writes, or for both. This trades bandwidth for data integrity.

The controller is a four-state machine, and all outputs are registered:

- **OFF**: disabled.
- **FULL**: full-rate strobes.
- **SLOW**: divided idle strobes.
- **HOLD**: stalled on FIFO backpressure.

The next state is decided from the inputs on every base cycle, with the following precedence:

1. OFF whenever the enable input is low.
2. HOLD when the bus is busy and the proof condition for the current direction holds.
3. FULL when the bus is busy or power saving is off.
4. SLOW otherwise.

This gives these transitions:

- *disable*: any state to OFF.
- *stall*: FULL/SLOW to HOLD.
- *release*: HOLD to FULL/SLOW.
- *wake*: SLOW to FULL.
- *doze*: FULL to SLOW.
- *start*: OFF to FULL/SLOW/HOLD.

Top module: `card_clk_gate`

## Requirements
- R1: After reset, and within one base cycle after `en` goes low, `tick_o` and `card_clk_o` are 0 and stay 0 while `en` is low, whatever the other inputs do.
- R2: With `en` high, no stall, and either `bus_busy` high or `pwr_save` low, `tick_o` is 1 on every base cycle, starting one cycle after the inputs are applied.
- R3: With `en` and `pwr_save` high and `bus_busy` low, consecutive strobes are exactly `2^idle_div + 1` base cycles apart, for every `idle_div` value 0..7.
- R4: When `bus_busy` rises during idle divided clocking, `tick_o` is 1 on the next base cycle, without waiting for the divided period to end.
- R5: A change of `idle_div` while idle restarts the divider, so the first strobe comes `2^idle_div + 1` cycles after the change (new value). Entering idle from full rate also starts a fresh period.
- R6: With `rd_hold_en`, `bus_busy` and `xfer_read` high (read), `tick_o` stays 0 while `fifo_full` is 1. With `rd_hold_en` low, or during a write, `fifo_full` has no effect.
- R7: With `wr_hold_en` and `bus_busy` high and `xfer_read` low (write), `tick_o` stays 0 while `fifo_empty` is 1. During a read, `fifo_empty` has no effect.
- R8: Once the FIFO condition that caused a stall is removed, `tick_o` is 1 on the next base cycle.
- R9: `card_clk_o` inverts on each cycle where `tick_o` is 1 and holds otherwise, except that it is forced low when disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base card clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Interface enable |
| pwr_save | input | 1 | Divide the clock while the bus is idle |
| idle_div | input | DIV_W (3) | Idle divider exponent N, divisor is 2^N+1 |
| rd_hold_en | input | 1 | Stall reads when the FIFO is full |
| wr_hold_en | input | 1 | Stall writes when the FIFO is empty |
| bus_busy | input | 1 | Bus is active (command or data in progress) |
| xfer_read | input | 1 | 1 = read transfer, 0 = write transfer |
| fifo_full | input | 1 | Receive FIFO full |
| fifo_empty | input | 1 | Transmit FIFO empty |
| tick_o | output | 1 | One-cycle card clock enable strobe |
| card_clk_o | output | 1 | Card clock, toggles on each strobe |

## Verification
The idle divider is swept through all eight values, and the gap between two strobes is measured after a full period has settled. This separates a correct power-of-two-plus-one divisor from off-by-one and wrong-exponent errors.

Read and write stalls are each driven with the matching FIFO flag and the opposite one. They are also driven with the proof enable cleared. These cases show that each hold reacts only to its own direction and flag, and that strobes resume one cycle after release.

Further directed patterns cover the following:
- waking from the middle of a long idle period;
- changing the divider in the middle of a period;
- busy activity while disabled.

These show immediate resumption, the restart of the counter, and a fully silent output when disabled.

// File: rtl/card_clk_gate_pkg.sv
package card_clk_gate_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_FULL = 2'd1,
        ST_SLOW = 2'd2,
        ST_HOLD = 2'd3
    } ccg_state_t;

    // Idle divisor for exponent n: 2^n + 1 base cycles per strobe.
    function automatic int unsigned ccg_divisor(input int unsigned n);
        return (32'd1 << n) + 32'd1;
    endfunction

endpackage

// File: rtl/ccg_policy.sv
module ccg_policy
    import card_clk_gate_pkg::*;
(
    input  logic       en,
    input  logic       pwr_save,
    input  logic       bus_busy,
    input  logic       xfer_read,
    input  logic       rd_hold_en,
    input  logic       wr_hold_en,
    input  logic       fifo_full,
    input  logic       fifo_empty,
    output ccg_state_t nxt_state
);

    logic rd_stall;
    logic wr_stall;

    // Read side: no room to accept data. Write side: nothing to send.
    assign rd_stall = rd_hold_en && xfer_read && fifo_full;
    assign wr_stall = wr_hold_en && !xfer_read && fifo_empty;

    always_comb begin
        if (!en) begin
            nxt_state = ST_OFF;
        end else if (bus_busy && (rd_stall || wr_stall)) begin
            nxt_state = ST_HOLD;
        end else if (bus_busy || !pwr_save) begin
            nxt_state = ST_FULL;
        end else begin
            nxt_state = ST_SLOW;
        end
    end

endmodule

// File: rtl/ccg_divider.sv
module ccg_divider
    import card_clk_gate_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_next,
    input  logic [DIV_W-1:0] idle_div,
    output logic             fire
);

    localparam int CNT_W = 1 << DIV_W;

    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic             div_chg;

    assign div_chg  = (idle_div != div_q);
    assign last_cnt = CNT_W'(ccg_divisor(32'(div_q)) - 32'd1);
    assign fire     = slow_next && !div_chg && (cnt_q == last_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
        end else begin
            div_q <= idle_div;
            if (!slow_next) begin
                cnt_q <= '0;
            end else if (div_chg) begin
                // Restart: count as if a strobe happened one cycle ago.
                cnt_q <= CNT_W'(1);
            end else if (cnt_q == last_cnt) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // R3: the count never reaches the divisor of the stored field
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) < ccg_divisor(32'(div_q)));

    // R5: a field change clears the count for a fresh period
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_next && div_chg) |=> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/card_clk_gate.sv
module card_clk_gate
    import card_clk_gate_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pwr_save,
    input  logic [DIV_W-1:0] idle_div,
    input  logic             rd_hold_en,
    input  logic             wr_hold_en,
    input  logic             bus_busy,
    input  logic             xfer_read,
    input  logic             fifo_full,
    input  logic             fifo_empty,
    output logic             tick_o,
    output logic             card_clk_o
);

    ccg_state_t state_q;
    ccg_state_t nxt_state;
    logic       slow_fire;
    logic       tick_nxt;

    ccg_policy u_policy (
        .en         (en),
        .pwr_save   (pwr_save),
        .bus_busy   (bus_busy),
        .xfer_read  (xfer_read),
        .rd_hold_en (rd_hold_en),
        .wr_hold_en (wr_hold_en),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .nxt_state  (nxt_state)
    );

    ccg_divider #(.DIV_W(DIV_W)) u_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_next (nxt_state == ST_SLOW),
        .idle_div  (idle_div),
        .fire      (slow_fire)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= nxt_state;
        end
    end

    // Strobe decision for the state being entered
    always_comb begin
        unique case (nxt_state)
            ST_FULL: tick_nxt = 1'b1;
            ST_SLOW: tick_nxt = slow_fire;
            ST_HOLD: tick_nxt = 1'b0;
            default: tick_nxt = 1'b0;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_o     <= 1'b0;
            card_clk_o <= 1'b0;
        end else begin
            tick_o <= tick_nxt;
            if (nxt_state == ST_OFF) begin
                card_clk_o <= 1'b0;
            end else begin
                card_clk_o <= card_clk_o ^ tick_nxt;
            end
        end
    end

    // R1: disabled means silent outputs one cycle later
    a_r1_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!tick_o && !card_clk_o));

    // R2 and R4: busy (or save off) without stall gives a strobe next cycle
    a_r2_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (bus_busy || !pwr_save)
            && !(bus_busy && rd_hold_en && xfer_read && fifo_full)
            && !(bus_busy && wr_hold_en && !xfer_read && fifo_empty))
        |=> tick_o);

    // R6: read hold on a full FIFO
    a_r6_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bus_busy && rd_hold_en && xfer_read && fifo_full) |=> !tick_o);

    // R7: write hold on an empty FIFO
    a_r7_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bus_busy && wr_hold_en && !xfer_read && fifo_empty) |=> !tick_o);

    // R9: card clock flips exactly on strobes while enabled
    a_r9_clk_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF) |-> (card_clk_o == ($past(card_clk_o) ^ tick_o)));

endmodule

// File: tb/card_clk_gate_tb_top.sv
module card_clk_gate_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       pwr_save = 1'b0;
    logic [2:0] idle_div = 3'd0;
    logic       rd_hold_en = 1'b0;
    logic       wr_hold_en = 1'b0;
    logic       bus_busy = 1'b0;
    logic       xfer_read = 1'b0;
    logic       fifo_full = 1'b0;
    logic       fifo_empty = 1'b0;
    logic       tick_o;
    logic       card_clk_o;

    int checks = 0;
    int errors = 0;

    // Expected idle strobe spacing for idle_div = 0..7 (2^N + 1)
    localparam int unsigned GAP_TAB [8] = '{2, 3, 5, 9, 17, 33, 65, 129};

    always #4 clk = ~clk;

    card_clk_gate #(.DIV_W(3)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .pwr_save   (pwr_save),
        .idle_div   (idle_div),
        .rd_hold_en (rd_hold_en),
        .wr_hold_en (wr_hold_en),
        .bus_busy   (bus_busy),
        .xfer_read  (xfer_read),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .tick_o     (tick_o),
        .card_clk_o (card_clk_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        for (int k = 0; k < 400; k++) begin
            if (tick_o) return;
            step();
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit ok;
        bit prev_clk;

        step();
        // R1: reset state
        chk(!tick_o && !card_clk_o, "R1 reset", int'(tick_o), 0);
        rst_n = 1'b1;

        // R1: disabled with bus activity produces nothing
        bus_busy = 1'b1;
        ok = 1'b1;
        for (int k = 0; k < 20; k++) begin
            step();
            if (tick_o || card_clk_o) ok = 1'b0;
        end
        chk(ok, "R1 disabled silent", int'(ok), 1);

        // R2: full rate when busy, R9 toggle each cycle
        en = 1'b1;
        step();
        ok = 1'b1;
        prev_clk = card_clk_o;
        for (int k = 0; k < 10; k++) begin
            step();
            if (!tick_o || card_clk_o == prev_clk) ok = 1'b0;
            prev_clk = card_clk_o;
        end
        chk(ok, "R2 busy full rate", int'(ok), 1);
        chk(ok, "R9 toggles per strobe", int'(ok), 1);

        // R2: full rate when idle but save off
        bus_busy = 1'b0;
        ok = 1'b1;
        for (int k = 0; k < 10; k++) begin
            step();
            if (!tick_o) ok = 1'b0;
        end
        chk(ok, "R2 save off full rate", int'(ok), 1);

        // R3: divider table walk
        pwr_save = 1'b1;
        for (int i = 0; i < 8; i++) begin
            int gap;
            idle_div = 3'(i);
            step();
            wait_tick();
            step();
            gap = 1;
            while (!tick_o && gap < 300) begin
                step();
                gap++;
            end
            chk(gap == int'(GAP_TAB[i]), "R3 idle gap", gap, int'(GAP_TAB[i]));
        end

        // R9: card clock holds between idle strobes
        idle_div = 3'd3;
        wait_tick();
        step();
        prev_clk = card_clk_o;
        step();
        chk(card_clk_o == prev_clk && !tick_o, "R9 hold between strobes",
            int'(card_clk_o), int'(prev_clk));

        // R4: wake mid-period
        idle_div = 3'd7;
        step();
        wait_tick();
        for (int k = 0; k < 20; k++) step();
        bus_busy = 1'b1;
        step();
        chk(tick_o == 1'b1, "R4 wake immediate", int'(tick_o), 1);
        bus_busy = 1'b0;

        // R5: divider change mid-period restarts count
        idle_div = 3'd3;
        step();
        wait_tick();
        for (int k = 0; k < 4; k++) step();
        idle_div = 3'd1;
        ok = 1'b1;
        step();
        if (tick_o) ok = 1'b0;
        step();
        if (tick_o) ok = 1'b0;
        step();
        chk(ok && tick_o, "R5 restart after change", int'(tick_o), 1);

        // R6: read hold on full FIFO
        bus_busy = 1'b1;
        xfer_read = 1'b1;
        rd_hold_en = 1'b1;
        fifo_full = 1'b1;
        ok = 1'b1;
        for (int k = 0; k < 10; k++) begin
            step();
            if (tick_o) ok = 1'b0;
        end
        chk(ok, "R6 read stalled", int'(ok), 1);
        fifo_full = 1'b0;
        step();
        chk(tick_o == 1'b1, "R8 read resume", int'(tick_o), 1);

        // R6: full FIFO ignored without read proof
        rd_hold_en = 1'b0;
        fifo_full = 1'b1;
        step();
        chk(tick_o == 1'b1, "R6 ignored when proof off", int'(tick_o), 1);

        // R6: full FIFO ignored during write
        rd_hold_en = 1'b1;
        xfer_read = 1'b0;
        step();
        chk(tick_o == 1'b1, "R6 ignored on write", int'(tick_o), 1);
        fifo_full = 1'b0;

        // R7: write hold on empty FIFO
        wr_hold_en = 1'b1;
        fifo_empty = 1'b1;
        ok = 1'b1;
        for (int k = 0; k < 10; k++) begin
            step();
            if (tick_o) ok = 1'b0;
        end
        chk(ok, "R7 write stalled", int'(ok), 1);
        fifo_empty = 1'b0;
        step();
        chk(tick_o == 1'b1, "R8 write resume", int'(tick_o), 1);

        // R7: empty FIFO ignored during read
        xfer_read = 1'b1;
        fifo_empty = 1'b1;
        step();
        chk(tick_o == 1'b1, "R7 ignored on read", int'(tick_o), 1);
        fifo_empty = 1'b0;

        // R1: clearing enable drops outputs next cycle
        en = 1'b0;
        step();
        chk(!tick_o && !card_clk_o, "R1 disable low", int'(card_clk_o), 0);

        // R5: re-enable into idle starts a fresh period
        en = 1'b1;
        bus_busy = 1'b0;
        idle_div = 3'd2;
        step();
        wait_tick();
        begin
            int gap;
            step();
            gap = 1;
            while (!tick_o && gap < 300) begin
                step();
                gap++;
            end
            chk(gap == 5, "R5 fresh period after enable", gap, 5);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule